// File: doc/BRIEF.md
# Six-Level Hardware Return Stack

This block keeps the return addresses of a small processor core in dedicated storage that no program can read or write. It has no stack pointer. Each time the core enters a subroutine or takes an interrupt, it pushes its 12-bit program counter together with a one-bit tag that gives the reason for the push. On a return it pops the top entry and gets back both the address and the tag. The current top entry is always shown on the outputs. A pop takes the value shown during the cycle in which the pop strobe is high.

The depth is a fixed six levels. The stack never blocks and never traps. A push onto a full stack writes the new value on top, moves every other entry one place deeper and drops the deepest one. A one-cycle overflow pulse reports the drop. A pop on an empty stack returns zero and raises a one-cycle underflow pulse. The occupancy count and the full and empty status let the surrounding logic see how deep the nesting has gone.

Top module: `ret_stack`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the stack is emptied. After that edge the level is 0, empty is 1, full is 0, the top-entry outputs read 0, and both event pulses are 0.
- R2: A push without a pop stores the pushed PC on top, one edge later. Entries come back in last-in, first-out order. If the stack was not full, the level rises by one.
- R3: A pop without a push on a non-empty stack behaves as follows. The top entry is visible on the top outputs in the cycle in which the pop is asserted. At the edge, the remaining entries move up one place and the level falls by one.
- R4: A push without a pop when the level is 6 has these effects:
  - the new value goes on top;
  - the deepest entry is lost for good;
  - the level stays 6;
  - the overflow output is 1 for exactly the one cycle after that edge.
- R5: A pop without a push on an empty stack has these effects:
  - the top outputs read 0 during the pop;
  - the level stays 0;
  - the underflow output is 1 for the one cycle after the edge.
- R6: A push and a pop in the same cycle on a non-empty stack have these effects:
  - the old top is returned;
  - the top is replaced by the pushed value;
  - deeper entries are left unchanged;
  - the level does not change;
  - neither event pulse fires.
- R7: A push and a pop in the same cycle on an empty stack have these effects:
  - the pop returns 0;
  - underflow pulses;
  - the pushed value is stored;
  - the level becomes 1.
- R8: The reason tag is stored with each entry and comes back with that entry. The tag is 1 for an interrupt and 0 for a call.
- R9: Full is 1 exactly when the level is 6. Empty is 1 exactly when the level is 0.
- R10: A cycle with neither push nor pop leaves the entries and the level unchanged, and clears both event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push strobe |
| push_pc | input | 12 | Program counter value to push |
| push_irq | input | 1 | Reason for the push: 1 = interrupt, 0 = call |
| pop | input | 1 | Pop strobe |
| top_pc | output | 12 | Current top entry, or 0 when empty |
| top_irq | output | 1 | Tag of the current top entry, or 0 when empty |
| level | output | 3 | Occupancy, from 0 to 6 |
| full | output | 1 | Level equals 6 |
| empty | output | 1 | Level equals 0 |
| overflow | output | 1 | One-cycle pulse after a push that discarded the deepest entry |
| underflow | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
A wrong shift direction or a slot written at the wrong place shows up as a wrong top address. That error appears on the first pop that reaches the corrupted slot, which can be several returns after the faulty push. For this reason the stimulus drains the stack completely after each fill. A level count that drifts away from the stored entries shows up on full, empty or one of the event pulses at the next edge. It also shows up as a non-zero top value once the stack reports empty. The deepest slot is only exercised when the overflow path is taken, so the stack is filled past six and then emptied to prove that exactly one entry was lost.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;
endpackage

// File: rtl/retstk_ctrl.sv
module retstk_ctrl
    import retstk_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output stk_op_e          op,
    output logic [LVL_W-1:0] level,
    output logic             ovf,
    output logic             unf
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             ovf;
        logic             unf;
    } ctrl_t;

    ctrl_t c_d, c_q;
    stk_op_e op_c;

    always_comb begin
        c_d     = c_q;
        c_d.ovf = 1'b0;
        c_d.unf = 1'b0;
        op_c    = OP_HOLD;
        if (push && pop) begin
            if (c_q.level == '0) begin
                op_c     = OP_PUSH;
                c_d.unf  = 1'b1;
                c_d.level = LVL_W'(1);
            end else begin
                op_c = OP_SWAP;
            end
        end else if (push) begin
            op_c = OP_PUSH;
            if (c_q.level == LVL_MAX) begin
                c_d.ovf = 1'b1;
            end else begin
                c_d.level = c_q.level + LVL_W'(1);
            end
        end else if (pop) begin
            if (c_q.level == '0) begin
                c_d.unf = 1'b1;
            end else begin
                op_c      = OP_POP;
                c_d.level = c_q.level - LVL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign op    = op_c;
    assign level = c_q.level;
    assign ovf   = c_q.ovf;
    assign unf   = c_q.unf;

    // R9
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.level <= LVL_MAX);

    // R4
    ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.ovf |-> (c_q.level == LVL_MAX && !c_q.unf));

    // R5
    unf_low_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.unf |-> (c_q.level <= LVL_W'(1) && !c_q.ovf));

    // R2
    push_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && c_q.level != LVL_MAX) |=> (c_q.level != '0));
endmodule

// File: rtl/retstk_store.sv
module retstk_store
    import retstk_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int PC_W  = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  stk_op_e         op,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            wr_irq,
    output logic [PC_W-1:0] top_pc,
    output logic            top_irq
);
    typedef struct packed {
        logic            irq;
        logic [PC_W-1:0] pc;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } store_t;

    store_t s_d, s_q;
    slot_t  fresh;

    always_comb begin
        fresh = '{irq: wr_irq, pc: wr_pc};
        s_d   = s_q;
        case (op)
            OP_PUSH: begin
                s_d.slot[0] = fresh;
                for (int i = 1; i < DEPTH; i++) s_d.slot[i] = s_q.slot[i-1];
            end
            OP_POP: begin
                for (int i = 0; i < DEPTH - 1; i++) s_d.slot[i] = s_q.slot[i+1];
                s_d.slot[DEPTH-1] = '0;
            end
            OP_SWAP: s_d.slot[0] = fresh;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign top_pc  = s_q.slot[0].pc;
    assign top_irq = s_q.slot[0].irq;

    // R6
    swap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SWAP) |=> (s_q.slot[1] == $past(s_q.slot[1])));

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (top_pc == $past(wr_pc) && top_irq == $past(wr_irq)));

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(s_q));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import retstk_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int PC_W  = 12,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [PC_W-1:0]  push_pc,
    input  logic             push_irq,
    input  logic             pop,
    output logic [PC_W-1:0]  top_pc,
    output logic             top_irq,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             overflow,
    output logic             underflow
);
    stk_op_e op;

    retstk_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .op    (op),
        .level (level),
        .ovf   (overflow),
        .unf   (underflow)
    );

    retstk_store #(.DEPTH(DEPTH), .PC_W(PC_W)) i_store (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wr_pc   (push_pc),
        .wr_irq  (push_irq),
        .top_pc  (top_pc),
        .top_irq (top_irq)
    );

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (top_pc == '0 && !top_irq));
endmodule

// File: tb/test_ret_stack.sv
`timescale 1ns/1ps
module test_ret_stack;
    logic        clk = 1'b0;
    logic        rst;
    logic        push, pop, push_irq;
    logic [11:0] push_pc;
    logic [11:0] top_pc;
    logic        top_irq, full, empty, overflow, underflow;
    logic [2:0]  level;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [11:0] cap_pc;
    logic        cap_irq;

    always #2.5 clk = ~clk;

    ret_stack i_ret_stack (
        .clk(clk), .rst(rst), .push(push), .push_pc(push_pc), .push_irq(push_irq),
        .pop(pop), .top_pc(top_pc), .top_irq(top_irq), .level(level),
        .full(full), .empty(empty), .overflow(overflow), .underflow(underflow)
    );

    typedef struct packed {
        logic        p;
        logic        q;
        logic        irq;
        logic [11:0] pc;
        logic [11:0] eret;
        logic        eirq;
        logic [2:0]  elev;
        logic        eovf;
        logic        eunf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,12'h101,12'h000,1'b0,3'd1,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,12'h202,12'h101,1'b0,3'd2,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,12'h303,12'h202,1'b1,3'd3,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,12'h000,12'h303,1'b0,3'd2,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,12'h4A4,12'h202,1'b1,3'd2,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,12'h000,12'h4A4,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,12'h000,12'h101,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,12'h000,12'h000,1'b0,3'd0,1'b0,1'b1},
        '{1'b1,1'b1,1'b1,12'h555,12'h000,1'b0,3'd1,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,12'h000,12'h555,1'b1,3'd1,1'b0,1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic irq, input logic [11:0] pc);
        @(negedge clk);
        push = p; pop = q; push_irq = irq; push_pc = pc;
        #1;
        cap_pc  = top_pc;
        cap_irq = top_irq;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
    endtask

    initial begin
        rst = 1'b1; push = 1'b0; pop = 1'b0; push_irq = 1'b0; push_pc = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "level", level, 0);
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "top_pc", top_pc, 0);
        chk("R1", "pulses", {overflow, underflow}, 0);
        @(negedge clk); rst = 1'b0;

        // Vector walk: R2 R3 R5 R6 R7 R8 R10
        for (int k = 0; k < NV; k++) begin
            step(VECS[k].p, VECS[k].q, VECS[k].irq, VECS[k].pc);
            chk("R2 R3 R5 R6 R7", "returned pc", cap_pc, VECS[k].eret);
            chk("R8", "returned tag", cap_irq, VECS[k].eirq);
            chk("R2 R3 R6 R10", "level", level, VECS[k].elev);
            chk("R4", "overflow", overflow, VECS[k].eovf);
            chk("R5 R7", "underflow", underflow, VECS[k].eunf);
        end

        // Fill from level 1 to 6. R9
        for (int k = 1; k <= 5; k++) begin
            step(1'b1, 1'b0, 1'b0, 12'h610 + 12'(k));
            chk("R9", "full flag", full, (k == 5) ? 1 : 0);
            chk("R9", "empty flag", empty, 0);
        end
        // R4: push onto a full stack
        step(1'b1, 1'b0, 1'b1, 12'h616);
        chk("R4", "level at full push", level, 6);
        chk("R4", "overflow pulse", overflow, 1);
        chk("R4", "new top", top_pc, 12'h616);
        step(1'b0, 1'b0, 1'b0, 12'h000);
        chk("R4", "overflow single cycle", overflow, 0);
        chk("R10", "idle top", top_pc, 12'h616);
        // Drain: 0x616..0x611 come back, 0x555 has been lost (R4)
        for (int k = 6; k >= 1; k--) begin
            step(1'b0, 1'b1, 1'b0, 12'h000);
            chk("R3 R4", "drain order", cap_pc, 12'h610 + 12'(k));
            chk("R8", "drain tag", cap_irq, (k == 6) ? 1 : 0);
        end
        chk("R4", "oldest lost, empty", empty, 1);
        chk("R4", "top after drain", top_pc, 0);

        // R1: reset in the middle of use
        step(1'b1, 1'b0, 1'b1, 12'hABC);
        step(1'b1, 1'b0, 1'b0, 12'hDEF);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1", "level after reset", level, 0);
        chk("R1", "top after reset", top_pc, 0);
        chk("R1", "tag after reset", top_irq, 0);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL all: watchdog expired, actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule